// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a packed 32-bit calendar word, which an external calendar counter produces, and compares it with a set of alarm words that use the same packing. Each alarm channel has a 3-bit level selector. The selector decides how far up the calendar the comparison reaches. It starts from seconds and adds one field per level, so the highest level compares the full date including the year.

The comparison is only acted on when the count tick arrives. On that tick edge the channel samples its match. If the match is newly true, the channel's flag is set. The calendar counter advances on the same tick, so the flag appears one tick after the calendar first showed the matching value. One consequence is that an alarm set to the last second of the last year raises its flag on the same tick on which the counter wraps. Flags stay set until a per-channel clear strobe removes them.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After synchronous reset, every alarm flag is 0 and every channel's remembered sample is cleared, so a match already present at the first tick sets the flag.
- R2: The calendar word and each alarm word pack, from bit 0 upward: second [5:0], minute [11:6], hour [16:12], day [21:17], month [25:22], year [31:26].
- R3: Selector level L in 1..6 compares exactly the L lowest fields: 1 = second, 2 = + minute, 3 = + hour, 4 = + day, 5 = + month, 6 = + year. Fields above level L are ignored.
- R4: Selector values 0 and 7 disable the channel, and its flag never sets.
- R5: A match is sampled only in a cycle where `cnt_tick` is 1. The flag becomes 1 in the cycle after that tick cycle, and it never sets without a tick.
- R6: A match that stays true over consecutive ticks sets the flag only once. The flag sets again only after a tick on which the match was false.
- R7: A set flag stays at 1 regardless of the calendar value until `flag_clr` for that channel is 1. It reads 0 in the following cycle.
- R8: When a set and a clear of the same channel fall in the same cycle, the flag ends up at 1.
- R9: Channels are independent: the alarm, selector, clear and flag of one channel do not affect another channel.
- R10: An alarm equal to the top value (year 63, month 12, day 31, 23:59:59) at level 6 sets its flag on the tick taken while the calendar shows that top value, which is the tick on which the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | One-cycle count tick strobe |
| now_word | input | 32 | Current packed calendar value |
| alarm_words | input | 32*N_ALARM | Alarm values; channel i at bits [32*i+31:32*i] |
| alarm_sel | input | 3*N_ALARM | Level selectors; channel i at bits [3*i+2:3*i] |
| flag_clr | input | N_ALARM | Per-channel clear strobes |
| alarm_flag | output | N_ALARM | Sticky alarm flags, registered |

## Verification
The bench builds the block with its default of two channels and the six-field 32-bit packing. With this configuration every selector level can be reached, and so can both disabled codes and the year field's top value of 63. Having two channels makes it possible to clear one flag while the other is set, and to give the two channels different selectors in the same test. For each level, the bench makes one run where the first ignored field differs and one where the highest compared field differs, so every field boundary is tested from both sides.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFIELD = 6;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 3;

  typedef int fw_t [NFIELD];
  // widths from least significant field upward: sec, min, hour, day, month, year
  localparam fw_t FIELD_W = '{6, 6, 5, 5, 4, 6};

  function automatic int field_lsb(input int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += FIELD_W[i];
    return s;
  endfunction
endpackage

// File: rtl/cal_field_match.sv
module cal_field_match
  import cal_alarm_pkg::*;
(
  input  logic [WORD_W-1:0] now_word,
  input  logic [WORD_W-1:0] alarm_word,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit
);
  logic [NFIELD-1:0] eq;
  logic [NFIELD-1:0] used;

  for (genvar k = 0; k < NFIELD; k++) begin : g_fld
    localparam int LSB = field_lsb(k);
    localparam int W   = FIELD_W[k];
    assign eq[k]   = (now_word[LSB +: W] == alarm_word[LSB +: W]);
    assign used[k] = (sel > SEL_W'(k)) && (sel <= SEL_W'(NFIELD));
  end

  assign hit = (|used) && (&(eq | ~used));
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic flag_q;
  logic set_now;

  assign set_now = tick && hit && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (tick) prev_q <= hit;
      flag_q <= set_now || (flag_q && !clr);
    end
  end

  assign flag = flag_q;

  // R5
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(clr));

  // R6
  single_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && prev_q && !flag_q) |=> !flag_q);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && hit && !prev_q && clr) |=> flag_q);
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int N_ALARM = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cnt_tick,
  input  logic [WORD_W-1:0]          now_word,
  input  logic [WORD_W*N_ALARM-1:0]  alarm_words,
  input  logic [SEL_W*N_ALARM-1:0]   alarm_sel,
  input  logic [N_ALARM-1:0]         flag_clr,
  output logic [N_ALARM-1:0]         alarm_flag
);
  for (genvar i = 0; i < N_ALARM; i++) begin : g_ch
    logic             hit;
    logic [SEL_W-1:0] sel;
    assign sel = alarm_sel[SEL_W*i +: SEL_W];

    cal_field_match u_match (
      .now_word   (now_word),
      .alarm_word (alarm_words[WORD_W*i +: WORD_W]),
      .sel        (sel),
      .hit        (hit)
    );

    cal_alarm_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .tick (cnt_tick),
      .hit  (hit),
      .clr  (flag_clr[i]),
      .flag (alarm_flag[i])
    );

    // R4
    disabled_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_tick && (sel == '0 || sel == '1) && !alarm_flag[i]) |=> !alarm_flag[i]);
  end
endmodule

// File: tb/cal_alarm_cmp_tb.sv
module cal_alarm_cmp_tb;
  localparam int NA = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cnt_tick = 1'b0;
  logic [31:0]     now_word = '0;
  logic [32*NA-1:0] alarm_words = '0;
  logic [3*NA-1:0]  alarm_sel = '0;
  logic [NA-1:0]    flag_clr = '0;
  logic [NA-1:0]    alarm_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_alarm_cmp #(.N_ALARM(NA)) u_dut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .now_word(now_word),
    .alarm_words(alarm_words), .alarm_sel(alarm_sel),
    .flag_clr(flag_clr), .alarm_flag(alarm_flag));

  // field offsets: sec 0, min 6, hour 12, day 17, month 22, year 26
  int offs [6] = '{0, 6, 12, 17, 22, 26};

  function automatic logic [31:0] pk(input int yr, mo, dy, hr, mn, sc);
    return {yr[5:0], mo[3:0], dy[4:0], hr[4:0], mn[5:0], sc[5:0]};
  endfunction

  task automatic chk(input string req, input logic [NA-1:0] got, input logic [NA-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: alarm_flag=%b expected %b", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick();
    cnt_tick = 1'b1; step(); cnt_tick = 1'b0;
  endtask

  // second 62 never occurs in an alarm here: clears each channel's sample, then flags
  task automatic prime();
    now_word = 32'h0000_003E;
    tick();
    flag_clr = '1; step(); flag_clr = '0;
  endtask

  localparam logic [31:0] A = 32'(((21*16 + 7)*32 + 14)*32*64*64 + (9*64 + 33)*64 + 45);

  task automatic t_reset();
    rst = 1'b1; step(); step();
    chk("R1 reset", alarm_flag, 2'b00);
    alarm_words[31:0] = A; alarm_sel[2:0] = 3'd6; now_word = A;
    step();
    rst = 1'b0;
    tick();
    chk("R1 first tick", alarm_flag, 2'b01);
  endtask

  task automatic t_levels();
    alarm_words = {32'hFFFF_FFFF, A}; alarm_sel = {3'd0, 3'd0};
    for (int l = 1; l <= 6; l++) begin
      alarm_sel[2:0] = 3'(l);
      if (l < 6) begin
        prime();
        now_word = A ^ (32'd1 << offs[l]);
        tick();
        chk("R3 ignored field", alarm_flag, 2'b01);
      end
      prime();
      now_word = A ^ (32'd1 << offs[l-1]);
      tick();
      chk("R2 compared field", alarm_flag, 2'b00);
    end
  endtask

  task automatic t_disabled();
    alarm_words = {A, A}; alarm_sel = {3'd7, 3'd0};
    prime(); now_word = A; tick(); tick();
    chk("R4 sel 0 and 7", alarm_flag, 2'b00);
  endtask

  task automatic t_delay();
    alarm_words = {32'hFFFF_FFFF, A}; alarm_sel = {3'd0, 3'd6};
    prime(); now_word = A;
    step(); step();
    chk("R5 no tick", alarm_flag, 2'b00);
    tick();
    chk("R5 after tick", alarm_flag, 2'b01);
  endtask

  task automatic t_once();
    flag_clr = 2'b01; step(); flag_clr = '0;
    tick();
    chk("R6 held match", alarm_flag, 2'b00);
    now_word = A ^ 32'd1; tick();
    now_word = A; tick();
    chk("R6 new edge", alarm_flag, 2'b01);
  endtask

  task automatic t_sticky();
    now_word = A ^ 32'd2; tick(); tick(); step();
    chk("R7 held", alarm_flag, 2'b01);
    flag_clr = 2'b01; step(); flag_clr = '0;
    chk("R7 cleared", alarm_flag, 2'b00);
  endtask

  task automatic t_setwins();
    prime(); now_word = A;
    cnt_tick = 1'b1; flag_clr = 2'b01; step(); cnt_tick = 1'b0; flag_clr = '0;
    chk("R8 set over clear", alarm_flag, 2'b01);
  endtask

  task automatic t_indep();
    alarm_words = {pk(3, 2, 1, 0, 0, 7), A}; alarm_sel = {3'd6, 3'd1};
    prime(); now_word = A; tick();
    chk("R9 one channel", alarm_flag, 2'b01);
    now_word = pk(3, 2, 1, 0, 0, 7); tick();
    chk("R9 both", alarm_flag, 2'b11);
    flag_clr = 2'b10; step(); flag_clr = '0;
    chk("R9 clear one", alarm_flag, 2'b01);
  endtask

  task automatic t_top();
    alarm_words = {pk(63, 12, 31, 23, 59, 59), A}; alarm_sel = {3'd6, 3'd0};
    prime(); now_word = pk(63, 12, 31, 23, 59, 58); tick();
    chk("R10 before top", alarm_flag, 2'b00);
    now_word = pk(63, 12, 31, 23, 59, 59); tick();
    chk("R10 wrap tick", alarm_flag, 2'b10);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2;
    t_reset();
    t_levels();
    t_disabled();
    t_delay();
    t_once();
    t_sticky();
    t_setwins();
    t_indep();
    t_top();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule